// File: doc/BRIEF.md
# Interrupt Arbiter with Illegal-Condition Trap

This block holds the interrupt and fault-trap logic of a small 8-bit controller core. It watches an external interrupt pin and a timer event strobe, and it keeps a program status register with pending flags, enable flags and the global enable. It tells the core, with a one-cycle pulse and a two-bit code, when to take an interrupt vector and which vector to take. The instruction decoder, ALU, timer counter and serial shifter sit outside the block. Only their strobes and flag bits come in.

The block also supplies the fill values for unmapped memory. This is how runaway code gets caught. Any program fetch at or above the top of mapped program memory returns opcode 0x00, and 0x00 is the software-trap opcode. Unmapped data memory reads as 0xFF. If the stack is popped past its start, the return address becomes 0xFFFF, that fetch lands in unmapped program memory, and the core traps. The software trap always yields to an enabled, pending hardware interrupt. Taking it leaves the global enable as it was, so hardware interrupts can still nest on top of the trap handler.

The stack pointer is tracked here as well. It counts down on a call and up on a return.

Top module: `irq_trap_ctrl`

## Requirements
- R1: One clock edge after a fetch address is presented, `op_out` holds 0x00 if `prog_addr` is 0x0300 or higher. Otherwise it holds `fetch_op`.
- R2: One edge after `data_addr` is presented, `data_out` holds the following:
  - the status register for address 0xEF;
  - the control register for address 0xEE;
  - `mem_rdata` for addresses below 0x30;
  - 0xFF for every other address, including 0x30 and 0x31.
- R3: Suppose `op_valid` is high and the effective opcode (as defined in R1) is 0x00 at clock edge E. With no hardware interrupt pending, `take_vec` is high with `vec_sel` = 00 after edge E+1, and it is low after edge E.
- R4: A software trap request is held and not taken while (IPND and ENI) or (TPND and ENTI) is true, whatever the value of GIE. It is taken one edge after that condition goes false.
- R5: Taking the software trap leaves GIE unchanged. Accepting a hardware interrupt clears GIE at the same edge that raises `take_vec`, even if a status write in the same cycle sets GIE.
- R6: A hardware interrupt is accepted only when GIE is 1 and a pending bit and its matching enable bit are both 1. When both sources qualify, the external source wins. The codes are 01 for external and 10 for timer.
- R7: `tmr_event` high at an edge sets TPND (status bit 5) at that edge. The vector, if enabled, follows one edge later.
- R8: The external pin passes through two synchronizer stages. IPND (status bit 3) is set at the third edge after a qualifying pin change, and the vector is taken at the fourth. Control bit 2 selects the edge: 0 means a rising edge and 1 means a falling edge. The other edge has no effect.
- R9: The status register layout, from bit 7 down to bit 0, is HC, C, TPND, ENTI, IPND, BUSY, ENI, GIE.
  - A write to 0xEF loads every bit except BUSY.
  - BUSY follows `shift_busy` one edge late.
  - A pending event in the same cycle as a write still sets its pending bit.
  - `alu_flag_we` loads HC and C.
- R10: `sp_q` decrements by one on `sp_push`, increments by one on `sp_pop`, and is unchanged when both are high.
- R11: After reset, `status_q` is 0x00, `ctrl_q` is 0x00, `sp_q` is 0x2F, `data_out` is 0xFF and `take_vec` is 0.
- R12: `take_vec` is high for exactly one cycle per accepted vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_irq_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_event | input | 1 | Timer underflow or capture strobe |
| op_valid | input | 1 | An instruction fetch happens this cycle |
| fetch_op | input | 8 | Opcode byte read from mapped program memory |
| prog_addr | input | 16 | Program fetch address |
| data_addr | input | 8 | Data address for reads and register writes |
| mem_rdata | input | 8 | Read data from mapped data RAM |
| reg_wr_en | input | 1 | Write strobe for the status and control registers |
| reg_wdata | input | 8 | Register write data |
| alu_flag_we | input | 1 | Load HC and C from the ALU |
| alu_hc | input | 1 | ALU half-carry |
| alu_c | input | 1 | ALU carry |
| shift_busy | input | 1 | Serial shifter busy flag |
| sp_push | input | 1 | Call: decrement the stack pointer |
| sp_pop | input | 1 | Return: increment the stack pointer |
| op_out | output | 8 | Opcode to the decoder, with the unmapped fill applied |
| data_out | output | 8 | Data read result, with the unmapped fill applied |
| status_q | output | 8 | Status register |
| ctrl_q | output | 8 | Control register |
| sp_q | output | 8 | Stack pointer |
| take_vec | output | 1 | One-cycle vector-take pulse |
| vec_sel | output | 2 | Vector code: 00 software, 01 external, 10 timer |

## Verification
Each result has its own latency, counted from the edge that samples the stimulus:
- Memory fill, register writes, TPND, BUSY and the stack pointer settle one edge after the stimulus.
- A software trap pulses one edge after the fetch that raised it.
- A timer vector pulses one edge after TPND is set.
- An external pin change sets IPND at the third edge and pulses the vector at the fourth.

The bench drives every input on the falling clock edge and checks the outputs on a later falling edge, after exactly the number of rising edges given above. For the cases where an event must have no effect, the bench counts `take_vec` pulses over an idle window and reads the status register afterwards.

// File: rtl/irq_trap_pkg.sv
package irq_trap_pkg;
  // vector-select codes handed to the core
  typedef enum logic [1:0] {
    VEC_SW  = 2'b00,
    VEC_EXT = 2'b01,
    VEC_TMR = 2'b10
  } vec_e;

  // status register bit positions
  localparam int GIE_B  = 0;
  localparam int ENI_B  = 1;
  localparam int BUSY_B = 2;
  localparam int IPND_B = 3;
  localparam int ENTI_B = 4;
  localparam int TPND_B = 5;
  localparam int C_B    = 6;
  localparam int HC_B   = 7;

  // control register bit that selects the external edge polarity
  localparam int EDGE_SEL_B = 2;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic fall_sel,
  output logic edge_hit
);
  logic [SYNC_STAGES:0] sh;
  logic now_lvl, old_lvl;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[SYNC_STAGES-1:0], pin};
  end

  assign now_lvl  = sh[SYNC_STAGES-1];
  assign old_lvl  = sh[SYNC_STAGES];
  assign edge_hit = fall_sel ? (old_lvl & ~now_lvl) : (now_lvl & ~old_lvl);
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_trap_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DAW = 8,
  parameter logic [DAW-1:0] ST_ADDR = 8'hEF,
  parameter logic [DAW-1:0] CT_ADDR = 8'hEE
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [DAW-1:0] wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           tmr_evt,
  input  logic           ext_evt,
  input  logic           accept_hw,
  input  logic           shift_busy,
  input  logic           alu_we,
  input  logic           alu_hc,
  input  logic           alu_c,
  output logic [DW-1:0]  status_q,
  output logic [DW-1:0]  ctrl_q
);
  logic [DW-1:0] status_d;
  logic st_wr, ct_wr;

  assign st_wr = wr_en && (wr_addr == ST_ADDR);
  assign ct_wr = wr_en && (wr_addr == CT_ADDR);

  always_comb begin
    status_d = status_q;
    if (alu_we) begin
      status_d[HC_B] = alu_hc;
      status_d[C_B]  = alu_c;
    end
    if (st_wr) status_d = wr_data;
    status_d[BUSY_B] = shift_busy;
    if (tmr_evt)   status_d[TPND_B] = 1'b1;
    if (ext_evt)   status_d[IPND_B] = 1'b1;
    if (accept_hw) status_d[GIE_B]  = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      ctrl_q   <= '0;
    end else begin
      status_q <= status_d;
      if (ct_wr) ctrl_q <= wr_data;
    end
  end

  // R5: an accepted hardware interrupt always drops the global enable
  a_r5_gie_drop: assert property (@(posedge clk) disable iff (rst)
    accept_hw |=> !status_q[GIE_B]);
  // R7: a timer strobe leaves its pending flag set
  a_r7_tpnd_set: assert property (@(posedge clk) disable iff (rst)
    tmr_evt |=> status_q[TPND_B]);
  // R8: a detected external edge leaves its pending flag set
  a_r8_ipnd_set: assert property (@(posedge clk) disable iff (rst)
    ext_evt |=> status_q[IPND_B]);
endmodule

// File: rtl/irq_vec_arbiter.sv
module irq_vec_arbiter
  import irq_trap_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] status_q,
  input  logic          sw_hit,
  output logic          accept_hw,
  output logic          take_vec,
  output logic [1:0]    vec_sel
);
  logic ext_rdy, tmr_rdy, hw_pend, sw_pend, sw_go;

  assign ext_rdy   = status_q[IPND_B] & status_q[ENI_B];
  assign tmr_rdy   = status_q[TPND_B] & status_q[ENTI_B];
  assign hw_pend   = ext_rdy | tmr_rdy;
  assign accept_hw = status_q[GIE_B] & hw_pend;
  assign sw_go     = sw_pend & ~hw_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      take_vec <= 1'b0;
      vec_sel  <= VEC_SW;
      sw_pend  <= 1'b0;
    end else begin
      take_vec <= 1'b0;
      if (accept_hw) begin
        take_vec <= 1'b1;
        vec_sel  <= ext_rdy ? VEC_EXT : VEC_TMR;
      end else if (sw_go) begin
        take_vec <= 1'b1;
        vec_sel  <= VEC_SW;
      end
      if (sw_hit)     sw_pend <= 1'b1;
      else if (sw_go) sw_pend <= 1'b0;
    end
  end

  // R4: the software vector is never taken over a pending enabled source
  a_r4_sw_yields: assert property (@(posedge clk) disable iff (rst)
    (take_vec && vec_sel == VEC_SW) |-> $past(!hw_pend));
  // R6: a hardware vector needs the global enable in the accepting cycle
  a_r6_hw_needs_gie: assert property (@(posedge clk) disable iff (rst)
    (take_vec && vec_sel != VEC_SW) |-> $past(status_q[GIE_B]));
endmodule

// File: rtl/irq_mem_fill.sv
module irq_mem_fill #(
  parameter int DW  = 8,
  parameter int PAW = 16,
  parameter int DAW = 8,
  parameter logic [PAW-1:0] ROM_TOP = 16'h0300,
  parameter logic [DAW-1:0] RAM_TOP = 8'h30,
  parameter logic [DAW-1:0] ST_ADDR = 8'hEF,
  parameter logic [DAW-1:0] CT_ADDR = 8'hEE,
  parameter logic [DW-1:0]  TRAP_OP = 8'h00
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PAW-1:0] prog_addr,
  input  logic [DW-1:0]  fetch_op,
  input  logic           op_valid,
  input  logic [DAW-1:0] data_addr,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [DW-1:0]  status_q,
  input  logic [DW-1:0]  ctrl_q,
  output logic [DW-1:0]  op_out,
  output logic [DW-1:0]  data_out,
  output logic           sw_hit
);
  logic [DW-1:0] op_eff, rd_eff;
  logic rom_hole, ram_hole;

  assign rom_hole = (prog_addr >= ROM_TOP);
  assign op_eff   = rom_hole ? TRAP_OP : fetch_op;
  assign sw_hit   = op_valid && (op_eff == TRAP_OP);
  assign ram_hole = (data_addr >= RAM_TOP) && (data_addr != ST_ADDR) && (data_addr != CT_ADDR);

  always_comb begin
    if (data_addr == ST_ADDR)      rd_eff = status_q;
    else if (data_addr == CT_ADDR) rd_eff = ctrl_q;
    else if (ram_hole)             rd_eff = '1;
    else                           rd_eff = mem_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_out   <= TRAP_OP;
      data_out <= '1;
    end else begin
      op_out   <= op_eff;
      data_out <= rd_eff;
    end
  end

  // R1: fetches beyond program memory come back as the trap opcode
  a_r1_rom_fill: assert property (@(posedge clk) disable iff (rst)
    (prog_addr >= ROM_TOP) |=> (op_out == TRAP_OP));
  // R2: unmapped data reads come back as all ones
  a_r2_data_fill: assert property (@(posedge clk) disable iff (rst)
    ram_hole |=> (data_out == '1));
endmodule

// File: rtl/irq_trap_ctrl.sv
module irq_trap_ctrl
  import irq_trap_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PAW = 16,
  parameter int DAW = 8,
  parameter logic [PAW-1:0] ROM_TOP  = 16'h0300,
  parameter logic [DAW-1:0] RAM_TOP  = 8'h30,
  parameter logic [DAW-1:0] ST_ADDR  = 8'hEF,
  parameter logic [DAW-1:0] CT_ADDR  = 8'hEE,
  parameter logic [DAW-1:0] SP_RESET = 8'h2F,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ext_irq_pin,
  input  logic           tmr_event,
  input  logic           op_valid,
  input  logic [DW-1:0]  fetch_op,
  input  logic [PAW-1:0] prog_addr,
  input  logic [DAW-1:0] data_addr,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           reg_wr_en,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           alu_flag_we,
  input  logic           alu_hc,
  input  logic           alu_c,
  input  logic           shift_busy,
  input  logic           sp_push,
  input  logic           sp_pop,
  output logic [DW-1:0]  op_out,
  output logic [DW-1:0]  data_out,
  output logic [DW-1:0]  status_q,
  output logic [DW-1:0]  ctrl_q,
  output logic [DAW-1:0] sp_q,
  output logic           take_vec,
  output logic [1:0]     vec_sel
);
  logic ext_evt, accept_hw, sw_hit;

  irq_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk(clk), .rst(rst), .pin(ext_irq_pin),
    .fall_sel(ctrl_q[EDGE_SEL_B]), .edge_hit(ext_evt)
  );

  irq_flag_regs #(.DW(DW), .DAW(DAW), .ST_ADDR(ST_ADDR), .CT_ADDR(CT_ADDR)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(data_addr),
    .wr_data(reg_wdata), .tmr_evt(tmr_event), .ext_evt(ext_evt),
    .accept_hw(accept_hw), .shift_busy(shift_busy), .alu_we(alu_flag_we),
    .alu_hc(alu_hc), .alu_c(alu_c), .status_q(status_q), .ctrl_q(ctrl_q)
  );

  irq_vec_arbiter #(.DW(DW)) arb_i (
    .clk(clk), .rst(rst), .status_q(status_q), .sw_hit(sw_hit),
    .accept_hw(accept_hw), .take_vec(take_vec), .vec_sel(vec_sel)
  );

  irq_mem_fill #(.DW(DW), .PAW(PAW), .DAW(DAW), .ROM_TOP(ROM_TOP), .RAM_TOP(RAM_TOP),
                 .ST_ADDR(ST_ADDR), .CT_ADDR(CT_ADDR), .TRAP_OP('0)) fill_i (
    .clk(clk), .rst(rst), .prog_addr(prog_addr), .fetch_op(fetch_op),
    .op_valid(op_valid), .data_addr(data_addr), .mem_rdata(mem_rdata),
    .status_q(status_q), .ctrl_q(ctrl_q), .op_out(op_out),
    .data_out(data_out), .sw_hit(sw_hit)
  );

  // stack pointer: down on call, up on return
  always_ff @(posedge clk) begin
    if (rst)                   sp_q <= SP_RESET;
    else if (sp_push && !sp_pop) sp_q <= sp_q - 1'b1;
    else if (sp_pop && !sp_push) sp_q <= sp_q + 1'b1;
  end

  // R10: a lone call moves the pointer down by one
  a_r10_sp_down: assert property (@(posedge clk) disable iff (rst)
    (sp_push && !sp_pop) |=> (sp_q == $past(sp_q) - 1'b1));
  // R10: a lone return moves the pointer up by one
  a_r10_sp_up: assert property (@(posedge clk) disable iff (rst)
    (sp_pop && !sp_push) |=> (sp_q == $past(sp_q) + 1'b1));
endmodule

// File: tb/irq_trap_ctrl_tb_top.sv
module irq_trap_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ext_irq_pin = 0, tmr_event = 0, op_valid = 0;
  logic [7:0] fetch_op = 8'h00;
  logic [15:0] prog_addr = 16'h0000;
  logic [7:0] data_addr = 8'h00, mem_rdata = 8'h00, reg_wdata = 8'h00;
  logic reg_wr_en = 0, alu_flag_we = 0, alu_hc = 0, alu_c = 0, shift_busy = 0;
  logic sp_push = 0, sp_pop = 0;
  logic [7:0] op_out, data_out, status_q, ctrl_q, sp_q;
  logic take_vec;
  logic [1:0] vec_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_trap_ctrl dut_i (
    .clk(clk), .rst(rst), .ext_irq_pin(ext_irq_pin), .tmr_event(tmr_event),
    .op_valid(op_valid), .fetch_op(fetch_op), .prog_addr(prog_addr),
    .data_addr(data_addr), .mem_rdata(mem_rdata), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .alu_flag_we(alu_flag_we), .alu_hc(alu_hc),
    .alu_c(alu_c), .shift_busy(shift_busy), .sp_push(sp_push), .sp_pop(sp_pop),
    .op_out(op_out), .data_out(data_out), .status_q(status_q), .ctrl_q(ctrl_q),
    .sp_q(sp_q), .take_vec(take_vec), .vec_sel(vec_sel)
  );

  // {kind(1=data read), address, input byte, expected byte}
  localparam logic [39:0] VECS [12] = '{
    {8'd0, 16'h0000, 8'hA5, 8'hA5},
    {8'd0, 16'h02FF, 8'h3C, 8'h3C},
    {8'd0, 16'h0300, 8'h77, 8'h00},
    {8'd0, 16'h04FF, 8'h12, 8'h00},
    {8'd0, 16'hFFFF, 8'hEE, 8'h00},
    {8'd1, 16'h0000, 8'h5A, 8'h5A},
    {8'd1, 16'h002F, 8'h81, 8'h81},
    {8'd1, 16'h0030, 8'h81, 8'hFF},
    {8'd1, 16'h0031, 8'h00, 8'hFF},
    {8'd1, 16'h00EE, 8'h42, 8'h00},
    {8'd1, 16'h00EF, 8'h42, 8'h00},
    {8'd1, 16'h0080, 8'h11, 8'hFF}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    data_addr = a;
    reg_wdata = d;
    reg_wr_en = 1'b1;
    tick();
    reg_wr_en = 1'b0;
  endtask

  task automatic idle_count(input int n, output int seen);
    seen = 0;
    repeat (n) begin
      tick();
      if (take_vec) seen++;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seen;
    repeat (3) tick();
    rst = 1'b0;
    // R11 reset state
    chk("R11 status", status_q, 8'h00);
    chk("R11 ctrl", ctrl_q, 8'h00);
    chk("R11 sp", sp_q, 8'h2F);
    chk("R11 data_out", data_out, 8'hFF);
    chk("R11 take", take_vec, 1'b0);

    // R1 / R2 fill table
    for (int i = 0; i < 12; i++) begin
      if (VECS[i][39:32] == 8'd0) begin
        prog_addr = VECS[i][31:16];
        fetch_op  = VECS[i][15:8];
        tick();
        chk("R1 op_out", op_out, VECS[i][7:0]);
      end else begin
        data_addr = VECS[i][23:16];
        mem_rdata = VECS[i][15:8];
        tick();
        chk("R2 data_out", data_out, VECS[i][7:0]);
      end
    end

    // R3 / R5 software trap keeps GIE
    wr(8'hEF, 8'h01);
    chk("R9 status write", status_q, 8'h01);
    prog_addr = 16'h0100; fetch_op = 8'h00; op_valid = 1'b1;
    tick();
    op_valid = 1'b0; fetch_op = 8'hA5;
    chk("R3 take early", take_vec, 1'b0);
    tick();
    chk("R3 take", take_vec, 1'b1);
    chk("R3 vec", vec_sel, 2'b00);
    chk("R5 gie kept", status_q, 8'h01);
    tick();
    chk("R12 pulse end", take_vec, 1'b0);

    // R7 / R6 / R5 timer vector
    wr(8'hEF, 8'h11);
    tmr_event = 1'b1;
    tick();
    tmr_event = 1'b0;
    chk("R7 tpnd", status_q, 8'h31);
    chk("R7 take early", take_vec, 1'b0);
    tick();
    chk("R7 take", take_vec, 1'b1);
    chk("R6 timer vec", vec_sel, 2'b10);
    chk("R5 gie cleared", status_q, 8'h30);
    // R6 GIE low blocks acceptance
    idle_count(4, seen);
    chk("R6 no take gie0", seen, 0);

    // R6 external beats timer; R4 software waits
    wr(8'hEF, 8'h3B);
    prog_addr = 16'h0200; fetch_op = 8'h00; op_valid = 1'b1;
    tick();
    op_valid = 1'b0; fetch_op = 8'hA5;
    chk("R6 take", take_vec, 1'b1);
    chk("R6 ext wins", vec_sel, 2'b01);
    idle_count(4, seen);
    chk("R4 sw blocked", seen, 0);
    wr(8'hEF, 8'h01);
    chk("R4 not yet", take_vec, 1'b0);
    tick();
    chk("R4 sw take", take_vec, 1'b1);
    chk("R4 sw vec", vec_sel, 2'b00);
    chk("R5 gie kept 2", status_q, 8'h01);

    // R9 pending beats write, BUSY mirror, ALU flags
    tmr_event = 1'b1;
    wr(8'hEF, 8'h00);
    tmr_event = 1'b0;
    chk("R9 pend beats write", status_q, 8'h20);
    shift_busy = 1'b1;
    tick();
    chk("R9 busy", status_q, 8'h24);
    wr(8'hEF, 8'h00);
    chk("R9 busy not writable", status_q, 8'h04);
    shift_busy = 1'b0;
    alu_flag_we = 1'b1; alu_hc = 1'b1; alu_c = 1'b0;
    tick();
    alu_flag_we = 1'b0;
    chk("R9 alu flags", status_q, 8'h80);

    // R8 rising edge with select 0
    wr(8'hEF, 8'h03);
    ext_irq_pin = 1'b1;
    tick(); tick(); tick();
    chk("R8 ipnd rise", status_q, 8'h0B);
    chk("R8 take early", take_vec, 1'b0);
    tick();
    chk("R8 take rise", take_vec, 1'b1);
    chk("R8 vec", vec_sel, 2'b01);
    tick();
    chk("R12 single pulse", take_vec, 1'b0);
    data_addr = 8'hEF;
    tick();
    chk("R2 status read", data_out, 8'h0A);

    // R8 falling ignored under select 0
    wr(8'hEF, 8'h03);
    ext_irq_pin = 1'b0;
    idle_count(5, seen);
    chk("R8 fall ignored", seen, 0);
    chk("R8 fall no ipnd", status_q, 8'h03);
    wr(8'hEE, 8'h04);
    chk("R8 ctrl", ctrl_q, 8'h04);
    ext_irq_pin = 1'b1;
    idle_count(5, seen);
    chk("R8 rise ignored", seen, 0);
    chk("R8 rise no ipnd", status_q, 8'h03);
    ext_irq_pin = 1'b0;
    tick(); tick(); tick();
    chk("R8 ipnd fall", status_q, 8'h0B);
    tick();
    chk("R8 take fall", take_vec, 1'b1);

    // R10 stack pointer
    sp_push = 1'b1;
    tick();
    chk("R10 push", sp_q, 8'h2E);
    tick();
    sp_pop = 1'b1;
    tick();
    chk("R10 both", sp_q, 8'h2D);
    sp_push = 1'b0;
    repeat (3) tick();
    chk("R10 pop", sp_q, 8'h30);
    tick();
    sp_pop = 1'b0;
    chk("R10 over-pop", sp_q, 8'h31);

    finish_run();
  end
endmodule